// File: doc/BRIEF.md
# Same-Address Busy Arbiter

This block sits in front of a two-port memory array and watches both ports for contention on a single word. Each port presents an enable, an address and a write strobe. When both ports are enabled on the same address, one port is named the holder and the other port is flagged busy. A busy port can still read, but its writes are withheld from the array. Enable and address alone decide contention; the write strobe plays no part, so two reads can also raise busy.

The holder is the port that was already enabled at that address in the previous cycle. When both ports arrive in the same cycle and neither was there before, the left port is chosen. The holder keeps the word for as long as the match lasts. Busy clears in the same cycle that either enable drops or the addresses differ. The write qualifiers are combinational in the current inputs and the registered holder, so a blocked write is never presented to the array.

When several devices are used side by side to widen the data path, one device is set to primary mode and the others to follower mode. A follower does not arbitrate. It takes per-port busy levels from outside, normally from the primary's busy outputs, and gates its writes the same way. In follower mode the block's own busy outputs stay inactive. Holding both external busy inputs high turns write blocking off.

Top module: `busy_arbiter`

## Requirements
- R1: In primary mode (`primary_sel`=1), both busy outputs are high (inactive) whenever either enable is low or the two addresses differ.
- R2: The write strobes have no effect on arbitration: two enabled read accesses to the same address drive the loser's busy output low.
- R3: If one port was enabled at an address in the previous cycle and the other port newly matches it, the earlier port wins, and only the newcomer's busy output goes low in the first cycle of the match.
- R4: If both ports begin a matching access in the same cycle and neither was enabled at that address in the previous cycle, the left port wins (`r_busy_n`=0, `l_busy_n`=1).
- R5: `l_busy_n` and `r_busy_n` are never low in the same cycle.
- R6: While the match continues, the holder does not change. Busy returns high in the same cycle that the match ends.
- R7: The write qualifier of a port is its enable AND its write strobe AND NOT its effective busy, in the same cycle. The holder's writes, and all writes when there is no contention, pass through.
- R8: In follower mode (`primary_sel`=0), both busy outputs stay high. The effective busy of each port is its external input, where a low level blocks that port's writes.
- R9: In follower mode, address matches have no effect: with both external busy inputs high, every enabled write passes.
- R10: After reset, with both ports idle, both busy outputs are high and both write qualifiers are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| primary_sel | input | 1 | 1 = arbitrate locally, 0 = follow external busy |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write strobe |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write strobe |
| l_busy_in_n | input | 1 | External busy for left port (follower mode), active low |
| r_busy_in_n | input | 1 | External busy for right port (follower mode), active low |
| l_busy_n | output | 1 | Left port busy, active low |
| r_busy_n | output | 1 | Right port busy, active low |
| l_wr_ok | output | 1 | Qualified left write to the array |
| r_wr_ok | output | 1 | Qualified right write to the array |

## Verification
A wrong holder register shows up on the first cycle of a persistent match. The wrong busy output drops, or the holder flips partway through a match, and the wrong port's write qualifier falls in that same cycle. A stale register from the previous cycle is caught by stepping one port in a cycle ahead of the other and checking who wins on arrival. Every combination of enables, addresses and strobes on a two-bit address space is swept in both modes, so a gating fault shows within one cycle of the input that exposes it.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
  localparam int NPORT = 2;
endpackage

// File: rtl/port_track.sv
module port_track #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              stayed
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // port was already enabled at the same address one cycle ago
  assign stayed = en & en_q & (addr_q == addr);
endmodule

// File: rtl/arb_core.sv
module arb_core
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              primary,
  input  logic [NPORT-1:0]  en,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [NPORT-1:0]  stayed,
  output owner_e            owner_now
);
  owner_e owner_q;
  owner_e pick;
  logic   match;

  assign match = primary & en[0] & en[1] & (addr_l == addr_r);

  always_comb begin
    pick = (stayed[1] && !stayed[0]) ? OWN_RIGHT : OWN_LEFT;
    if (!match)                  owner_now = OWN_NONE;
    else if (owner_q != OWN_NONE) owner_now = owner_q;
    else                         owner_now = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_now;
  end
endmodule

// File: rtl/write_gate.sv
module write_gate
  import busy_arb_pkg::*;
(
  input  logic [NPORT-1:0] en,
  input  logic [NPORT-1:0] wr,
  input  logic [NPORT-1:0] busy,
  output logic [NPORT-1:0] wr_ok
);
  for (genvar p = 0; p < NPORT; p++) begin : g_gate
    assign wr_ok[p] = en[p] & wr[p] & ~busy[p];
  end
endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
  import busy_arb_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              primary_sel,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  logic [NPORT-1:0]  en_v, wr_v, stayed_v, busy_v, ok_v, ext_busy_v;
  logic [ADDR_W-1:0] addr_v [NPORT];
  owner_e            owner_now;

  assign en_v       = {r_en, l_en};
  assign wr_v       = {r_wr, l_wr};
  assign ext_busy_v = {~r_busy_in_n, ~l_busy_in_n};
  assign addr_v[0]  = l_addr;
  assign addr_v[1]  = r_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_trk
    port_track #(.ADDR_W(ADDR_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .en(en_v[p]), .addr(addr_v[p]), .stayed(stayed_v[p])
    );
  end

  arb_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .primary(primary_sel), .en(en_v),
    .addr_l(l_addr), .addr_r(r_addr), .stayed(stayed_v), .owner_now(owner_now)
  );

  logic [NPORT-1:0] arb_busy;
  assign arb_busy = {owner_now == OWN_LEFT, owner_now == OWN_RIGHT};
  assign busy_v   = primary_sel ? arb_busy : ext_busy_v;

  write_gate u_gate (.en(en_v), .wr(wr_v), .busy(busy_v), .wr_ok(ok_v));

  assign l_busy_n = ~(primary_sel & arb_busy[0]);
  assign r_busy_n = ~(primary_sel & arb_busy[1]);
  assign l_wr_ok  = ok_v[0];
  assign r_wr_ok  = ok_v[1];
endmodule

// File: rtl/busy_arbiter_chk.sv
module busy_arbiter_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              primary_sel,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_wr,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_wr,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_ok,
  input logic              r_wr_ok
);
  logic same;
  assign same = l_en & r_en & (l_addr == r_addr);

  AST_NO_DOUBLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (primary_sel && !same) |-> (l_busy_n && r_busy_n)); // R1
  AST_LOSER_BLOCKED_L: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> !l_wr_ok); // R7
  AST_LOSER_BLOCKED_R: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> !r_wr_ok); // R7
  AST_HOLDER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (primary_sel && same && $past(primary_sel) && $past(same) && !$past(r_busy_n))
      |-> !r_busy_n); // R6
  AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !primary_sel |-> (l_busy_n && r_busy_n)); // R8
  AST_FOLLOWER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!primary_sel && !l_busy_in_n) |-> !l_wr_ok); // R8
  AST_FOLLOWER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!primary_sel && r_busy_in_n && r_en && r_wr) |-> r_wr_ok); // R9
endmodule

bind busy_arbiter busy_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_busy_arbiter.sv
`timescale 1ns/1ps
module sim_busy_arbiter;
  localparam int AW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic primary_sel, l_en, l_wr, r_en, r_wr, l_busy_in_n, r_busy_in_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  busy_arbiter #(.ADDR_W(AW)) u0 (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic le, logic [AW-1:0] la, logic lw,
                       logic re, logic [AW-1:0] ra, logic rw);
    @(negedge clk);
    l_en = le; l_addr = la; l_wr = lw;
    r_en = re; r_addr = ra; r_wr = rw;
    #2;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    primary_sel = 1; l_busy_in_n = 1; r_busy_in_n = 1;
    l_en = 0; r_en = 0; l_wr = 0; r_wr = 0; l_addr = 0; r_addr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R10 l_busy_n", l_busy_n, 1); chk("R10 r_busy_n", r_busy_n, 1);
    chk("R10 l_wr_ok", l_wr_ok, 0);   chk("R10 r_wr_ok", r_wr_ok, 0);
    @(negedge clk); rst_n = 1;

    // R1 R2 R4 R5 R7: sweep of simultaneous arrivals after an idle cycle
    for (int v = 0; v < 256; v++) begin
      logic le, re, lw, rw, m;
      logic [AW-1:0] la, ra;
      le = v[0]; re = v[1]; lw = v[2]; rw = v[3]; la = v[5:4]; ra = v[7:6];
      idle();
      drive(le, la, lw, re, ra, rw);
      m = le & re & (la == ra);
      chk("R1/R4 l_busy_n", l_busy_n, 1);
      chk("R2/R4 r_busy_n", r_busy_n, ~m);
      chk("R7 l_wr_ok", l_wr_ok, le & lw);
      chk("R7 r_wr_ok", r_wr_ok, re & rw & ~m);
    end

    // R3: earlier port wins, both orders, all addresses
    for (int a = 0; a < 4; a++) begin
      idle();
      drive(1, a[AW-1:0], 0, 0, 0, 0);
      drive(1, a[AW-1:0], 1, 1, a[AW-1:0], 1);
      chk("R3 left first r_busy_n", r_busy_n, 0);
      chk("R3 left first l_wr_ok", l_wr_ok, 1);
      chk("R3 left first r_wr_ok", r_wr_ok, 0);
      idle();
      drive(0, 0, 0, 1, a[AW-1:0], 0);
      drive(1, a[AW-1:0], 1, 1, a[AW-1:0], 1);
      chk("R3 right first l_busy_n", l_busy_n, 0);
      chk("R3 right first r_busy_n", r_busy_n, 1);
      chk("R3 right first l_wr_ok", l_wr_ok, 0);
      chk("R3 right first r_wr_ok", r_wr_ok, 1);
      // R6: holder kept while match continues
      repeat (3) begin
        drive(1, a[AW-1:0], 1, 1, a[AW-1:0], 0);
        chk("R6 held l_busy_n", l_busy_n, 0);
        chk("R6 held r_busy_n", r_busy_n, 1);
      end
      // R6: holder moves away, busy clears same cycle
      drive(1, a[AW-1:0], 1, 1, a[AW-1:0] + 2'd1, 0);
      chk("R6 release l_busy_n", l_busy_n, 1);
      chk("R6 release l_wr_ok", l_wr_ok, 1);
      // R6: holder drops enable
      drive(1, a[AW-1:0], 1, 1, a[AW-1:0] + 2'd1, 0);
      drive(1, a[AW-1:0], 1, 0, a[AW-1:0], 0);
      chk("R6 disable l_busy_n", l_busy_n, 1);
    end

    // R8 R9: follower sweep, matches ignored, external busy gates
    primary_sel = 0;
    for (int v = 0; v < 1024; v++) begin
      logic le, re, lw, rw, bl, br;
      logic [AW-1:0] la, ra;
      le = v[0]; re = v[1]; lw = v[2]; rw = v[3]; la = v[5:4]; ra = v[7:6];
      bl = v[8]; br = v[9];
      l_busy_in_n = bl; r_busy_in_n = br;
      drive(le, la, lw, re, ra, rw);
      chk("R8 l_busy_n", l_busy_n, 1);
      chk("R8 r_busy_n", r_busy_n, 1);
      chk("R8/R9 l_wr_ok", l_wr_ok, le & lw & bl);
      chk("R8/R9 r_wr_ok", r_wr_ok, re & rw & br);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule